// File: doc/BRIEF.md
# Stack Machine Instruction Type Decoder

This block sits at the front of a stack-oriented processor. Each cycle it can accept one 16-bit instruction word together with the instruction pointer (IP) of that word and two status bits for the top of the parameter stack: whether it is zero and whether it is a positive integer. It sorts the word into an instruction kind and works out the IP of the next instruction. It also produces the side results for the kinds that have them: a return-stack push for calls, a sub-opcode for the primitive unit, a count for the prefetch engine, and the three small fields of a packed word. Any illegal encoding produces a fault strobe.

Most kinds finish in one cycle. Their result is registered and appears the cycle after the word is accepted. A call through the method table takes two cycles. In the accept cycle the block issues a read request carrying the table index. The table answers one cycle later. During that cycle the block raises `stall` and ignores its input, and it then registers the table entry as the next IP.

Top module: `stk_insn_decoder`

## Requirements
- R1: `out_kind` is 8 when bit 15 of the accepted word is 1. Otherwise it is bits 14:12 of the word, zero-extended to 4 bits.
- R2: Kind 0 (prefetch) puts bits 11:0 on `pf_count` and advances the IP by one. When that count is zero, the word raises `fault_illegal`.
- R3: Kind 1 has no defined meaning and always raises `fault_illegal`.
- R4: Kind 2 is an unconditional branch. Its next IP is the current IP minus bits 11:0, read as a two's-complement value in the range -2048..2047.
- R5: Kind 3 adds the sign-extended 12-bit field to the IP when `tos_zero` is 1. When `tos_zero` is 0, the IP advances by one.
- R6: Kind 6 adds the sign-extended 12-bit field to the IP when `tos_pos` is 1. When `tos_pos` is 0, the IP advances by one.
- R7: Kind 5 is a relative call. It pushes IP+1 and sets the next IP to the current IP minus the sign-extended field. A zero field raises `fault_illegal`.
- R8: Kind 7 with a nonzero unsigned index asserts `mt_req`, with `mt_idx` equal to the index, in the accept cycle. The next cycle has `stall`=1 and `out_valid`=0, and input in that cycle is ignored. One cycle later the result shows next IP equal to the `mt_data` returned during the stall cycle, and a push of IP+1. Index zero raises `fault_class`, issues no request and does not stall.
- R9: Kind 4 puts bits 11:0 on `prim_op` and advances the IP by one. A zero sub-opcode raises `fault_illegal`.
- R10: A kind-8 word carries three fields: bits 14:10 on `pk_a`, bits 9:5 on `pk_b` and bits 4:0 on `pk_c`. It advances the IP by one, except that `pk_a` = 5'b11111 raises `fault_illegal`.
- R11: Any fault makes the next IP equal to the faulting word's own IP and suppresses the push. At most one fault strobe is high at a time.
- R12: A one-cycle kind produces `out_valid` exactly one cycle after acceptance. After reset, `out_valid`, `push_valid`, `stall`, both fault strobes and `next_ip` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present |
| in_word | input | 16 | Instruction word |
| in_ip | input | IPW | IP of the instruction word |
| tos_zero | input | 1 | Top of stack equals zero |
| tos_pos | input | 1 | Top of stack is a positive integer |
| stall | output | 1 | Waiting on the method table; input ignored |
| mt_req | output | 1 | Method table read request |
| mt_idx | output | 12 | Method table index |
| mt_data | input | IPW | Method table entry, one cycle after the request |
| out_valid | output | 1 | Decode result valid |
| out_kind | output | 4 | Instruction kind |
| next_ip | output | IPW | Next instruction pointer |
| push_valid | output | 1 | Return-stack push request |
| push_data | output | IPW | Return address to push |
| prim_op | output | 12 | Primitive sub-opcode |
| pf_count | output | 12 | Prefetch word count |
| pk_a | output | 5 | Packed field A |
| pk_b | output | 5 | Packed field B |
| pk_c | output | 5 | Packed field C |
| fault_illegal | output | 1 | Illegal instruction fault |
| fault_class | output | 1 | Method-table index type-safety fault |

## Verification
The bench checks the sign of each offset by branching and calling with the field at -1, -16 and -2048. A decoder that adds where it should subtract, or that zero-extends the field, lands on the wrong IP. Each kind that has a zero-literal trap is fed a zero literal. The bench checks that the IP then holds and that no push is issued, which catches a design that faults but still updates the IP or pushes. The method-table call is run with a second word offered during the stall cycle. A design that accepts that word, or that captures the table data one cycle too early or too late, shows a wrong result or an extra `out_valid`.

// File: rtl/stk_dec_pkg.sv
package stk_dec_pkg;

    localparam int WORD_W = 16;
    localparam int LIT_W  = 12;
    localparam int PK_W   = 5;
    localparam logic [PK_W-1:0] PK_RESERVED = '1;

    typedef enum logic [3:0] {
        K_FETCH = 4'd0,
        K_UNDEF = 4'd1,
        K_JMP   = 4'd2,
        K_JZ    = 4'd3,
        K_PRIM  = 4'd4,
        K_CALL  = 4'd5,
        K_JP    = 4'd6,
        K_METH  = 4'd7,
        K_PACK  = 4'd8
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [LIT_W-1:0] lit;
        logic [PK_W-1:0]  pa;
        logic [PK_W-1:0]  pb;
        logic [PK_W-1:0]  pc;
        logic             f_ill;
        logic             f_cls;
        logic             wants_tbl;
    } dec_s;

    function automatic kind_e kind_of(input logic [WORD_W-1:0] w);
        return w[15] ? K_PACK : kind_e'({1'b0, w[14:12]});
    endfunction

    function automatic logic [31:0] sext_lit(input logic [LIT_W-1:0] l);
        return {{(32-LIT_W){l[LIT_W-1]}}, l};
    endfunction

endpackage

// File: rtl/stk_dec_classify.sv
module stk_dec_classify
    import stk_dec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_s              dec
);
    always_comb begin
        dec           = '0;
        dec.kind      = kind_of(word);
        dec.lit       = word[LIT_W-1:0];
        if (dec.kind == K_PACK) begin
            dec.pa = word[14:10];
            dec.pb = word[9:5];
            dec.pc = word[4:0];
        end
        unique case (dec.kind)
            K_FETCH, K_PRIM, K_CALL: dec.f_ill = (dec.lit == '0);
            K_UNDEF:                 dec.f_ill = 1'b1;
            K_PACK:                  dec.f_ill = (dec.pa == PK_RESERVED);
            K_METH: begin
                dec.f_cls     = (dec.lit == '0);
                dec.wants_tbl = (dec.lit != '0);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/stk_dec_nextip.sv
module stk_dec_nextip
    import stk_dec_pkg::*;
#(
    parameter int IPW = 16
) (
    input  dec_s           dec,
    input  logic [IPW-1:0] ip,
    input  logic           tos_zero,
    input  logic           tos_pos,
    output logic [IPW-1:0] nxt,
    output logic           push
);
    logic [31:0]    off_full;
    logic [IPW-1:0] off;
    logic [IPW-1:0] seq;

    assign off_full = sext_lit(dec.lit);
    assign off      = off_full[IPW-1:0];
    assign seq      = ip + IPW'(1);

    always_comb begin
        nxt  = seq;
        push = 1'b0;
        unique case (dec.kind)
            K_JMP:  nxt = ip - off;
            K_JZ:   nxt = tos_zero ? ip + off : seq;
            K_JP:   nxt = tos_pos  ? ip + off : seq;
            K_CALL: begin
                nxt  = ip - off;
                push = 1'b1;
            end
            default: ;
        endcase
        if (dec.f_ill || dec.f_cls) begin
            nxt  = ip;
            push = 1'b0;
        end
    end
endmodule

// File: rtl/stk_insn_decoder.sv
module stk_insn_decoder
    import stk_dec_pkg::*;
#(
    parameter int IPW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [15:0]       in_word,
    input  logic [IPW-1:0]    in_ip,
    input  logic              tos_zero,
    input  logic              tos_pos,
    output logic              stall,
    output logic              mt_req,
    output logic [11:0]       mt_idx,
    input  logic [IPW-1:0]    mt_data,
    output logic              out_valid,
    output logic [3:0]        out_kind,
    output logic [IPW-1:0]    next_ip,
    output logic              push_valid,
    output logic [IPW-1:0]    push_data,
    output logic [11:0]       prim_op,
    output logic [11:0]       pf_count,
    output logic [4:0]        pk_a,
    output logic [4:0]        pk_b,
    output logic [4:0]        pk_c,
    output logic              fault_illegal,
    output logic              fault_class
);
    dec_s           dec;
    logic [IPW-1:0] calc_ip;
    logic           calc_push;
    logic           pend_q;
    logic [IPW-1:0] ret_q;
    logic           accept;

    stk_dec_classify u_cls (
        .word (in_word),
        .dec  (dec)
    );

    stk_dec_nextip #(.IPW(IPW)) u_nip (
        .dec      (dec),
        .ip       (in_ip),
        .tos_zero (tos_zero),
        .tos_pos  (tos_pos),
        .nxt      (calc_ip),
        .push     (calc_push)
    );

    assign accept = in_valid && !pend_q;
    assign mt_req = accept && dec.wants_tbl;
    assign mt_idx = dec.lit;
    assign stall  = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q        <= 1'b0;
            ret_q         <= '0;
            out_valid     <= 1'b0;
            out_kind      <= '0;
            next_ip       <= '0;
            push_valid    <= 1'b0;
            push_data     <= '0;
            prim_op       <= '0;
            pf_count      <= '0;
            pk_a          <= '0;
            pk_b          <= '0;
            pk_c          <= '0;
            fault_illegal <= 1'b0;
            fault_class   <= 1'b0;
        end else begin
            out_valid     <= 1'b0;
            push_valid    <= 1'b0;
            fault_illegal <= 1'b0;
            fault_class   <= 1'b0;
            if (pend_q) begin
                pend_q     <= 1'b0;
                out_valid  <= 1'b1;
                next_ip    <= mt_data;
                push_valid <= 1'b1;
                push_data  <= ret_q;
            end else if (accept) begin
                out_kind  <= dec.kind;
                prim_op   <= (dec.kind == K_PRIM)  ? dec.lit : '0;
                pf_count  <= (dec.kind == K_FETCH) ? dec.lit : '0;
                pk_a      <= dec.pa;
                pk_b      <= dec.pb;
                pk_c      <= dec.pc;
                push_data <= in_ip + IPW'(1);
                if (dec.wants_tbl) begin
                    pend_q <= 1'b1;
                    ret_q  <= in_ip + IPW'(1);
                end else begin
                    out_valid     <= 1'b1;
                    next_ip       <= calc_ip;
                    push_valid    <= calc_push;
                    fault_illegal <= dec.f_ill;
                    fault_class   <= dec.f_cls;
                end
            end
        end
    end
endmodule

// File: rtl/stk_dec_chk.sv
module stk_dec_chk #(
    parameter int IPW = 16
) (
    input logic           clk,
    input logic           rst,
    input logic [IPW-1:0] in_ip,
    input logic           stall,
    input logic           mt_req,
    input logic [IPW-1:0] mt_data,
    input logic           out_valid,
    input logic [3:0]     out_kind,
    input logic [IPW-1:0] next_ip,
    input logic           push_valid,
    input logic [IPW-1:0] push_data,
    input logic [4:0]     pk_a,
    input logic           fault_illegal,
    input logic           fault_class
);
    AST_FAULT_HOLDS_IP: assert property (@(posedge clk) disable iff (rst)
        out_valid && (fault_illegal || fault_class) |-> next_ip == $past(in_ip) && !push_valid); // R11
    AST_ONE_FAULT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fault_illegal, fault_class})); // R11
    AST_CALL_RETURN: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_kind == 4'd5 && push_valid |-> push_data == $past(in_ip) + IPW'(1)); // R7
    AST_REQ_STALLS: assert property (@(posedge clk) disable iff (rst)
        mt_req |=> stall && !out_valid); // R8
    AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall && out_valid && next_ip == $past(mt_data) && push_valid); // R8
    AST_PACK_RESERVED: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_kind == 4'd8 && pk_a == 5'h1F |-> fault_illegal); // R10
    AST_CLASS_KIND: assert property (@(posedge clk) disable iff (rst)
        fault_class |-> out_kind == 4'd7); // R8
endmodule

bind stk_insn_decoder stk_dec_chk #(.IPW(IPW)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .in_ip         (in_ip),
    .stall         (stall),
    .mt_req        (mt_req),
    .mt_data       (mt_data),
    .out_valid     (out_valid),
    .out_kind      (out_kind),
    .next_ip       (next_ip),
    .push_valid    (push_valid),
    .push_data     (push_data),
    .pk_a          (pk_a),
    .fault_illegal (fault_illegal),
    .fault_class   (fault_class)
);

// File: tb/stk_insn_decoder_tb_top.sv
module stk_insn_decoder_tb_top;
    localparam int IPW = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [15:0]    in_word = '0;
    logic [IPW-1:0] in_ip = '0;
    logic           tos_zero = 1'b0;
    logic           tos_pos = 1'b0;
    logic           stall, mt_req;
    logic [11:0]    mt_idx;
    logic [IPW-1:0] mt_data = '0;
    logic           out_valid;
    logic [3:0]     out_kind;
    logic [IPW-1:0] next_ip;
    logic           push_valid;
    logic [IPW-1:0] push_data;
    logic [11:0]    prim_op, pf_count;
    logic [4:0]     pk_a, pk_b, pk_c;
    logic           fault_illegal, fault_class;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    stk_insn_decoder #(.IPW(IPW)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .in_ip(in_ip),
        .tos_zero(tos_zero), .tos_pos(tos_pos), .stall(stall), .mt_req(mt_req),
        .mt_idx(mt_idx), .mt_data(mt_data), .out_valid(out_valid), .out_kind(out_kind),
        .next_ip(next_ip), .push_valid(push_valid), .push_data(push_data),
        .prim_op(prim_op), .pf_count(pf_count), .pk_a(pk_a), .pk_b(pk_b), .pk_c(pk_c),
        .fault_illegal(fault_illegal), .fault_class(fault_class)
    );

    typedef struct packed {
        logic [15:0] word;
        logic [15:0] ip;
        logic        tz;
        logic        tp;
        logic [3:0]  kind;
        logic [15:0] nxt;
        logic        push;
        logic [15:0] pdata;
        logic        fi;
        logic        fc;
        logic [14:0] aux;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{16'h2005, 16'h1000, 1'b0, 1'b0, 4'd2, 16'h0FFB, 1'b0, 16'h0, 1'b0, 1'b0, 15'h0, 8'd4},   // R4
        '{16'h2FFF, 16'h1000, 1'b0, 1'b0, 4'd2, 16'h1001, 1'b0, 16'h0, 1'b0, 1'b0, 15'h0, 8'd4},   // R4
        '{16'h3010, 16'h1000, 1'b1, 1'b0, 4'd3, 16'h1010, 1'b0, 16'h0, 1'b0, 1'b0, 15'h0, 8'd5},   // R5
        '{16'h3010, 16'h1000, 1'b0, 1'b1, 4'd3, 16'h1001, 1'b0, 16'h0, 1'b0, 1'b0, 15'h0, 8'd5},   // R5
        '{16'h3FF0, 16'h1000, 1'b1, 1'b0, 4'd3, 16'h0FF0, 1'b0, 16'h0, 1'b0, 1'b0, 15'h0, 8'd5},   // R5
        '{16'h6020, 16'h1000, 1'b0, 1'b1, 4'd6, 16'h1020, 1'b0, 16'h0, 1'b0, 1'b0, 15'h0, 8'd6},   // R6
        '{16'h6020, 16'h1000, 1'b1, 1'b0, 4'd6, 16'h1001, 1'b0, 16'h0, 1'b0, 1'b0, 15'h0, 8'd6},   // R6
        '{16'h5003, 16'h1000, 1'b0, 1'b0, 4'd5, 16'h0FFD, 1'b1, 16'h1001, 1'b0, 1'b0, 15'h0, 8'd7}, // R7
        '{16'h5800, 16'h1000, 1'b0, 1'b0, 4'd5, 16'h1800, 1'b1, 16'h1001, 1'b0, 1'b0, 15'h0, 8'd7}, // R7
        '{16'h5000, 16'h1000, 1'b0, 1'b0, 4'd5, 16'h1000, 1'b0, 16'h0, 1'b1, 1'b0, 15'h0, 8'd11},  // R11
        '{16'h0000, 16'h1000, 1'b0, 1'b0, 4'd0, 16'h1000, 1'b0, 16'h0, 1'b1, 1'b0, 15'h0, 8'd2},   // R2
        '{16'h0FFF, 16'h1000, 1'b0, 1'b0, 4'd0, 16'h1001, 1'b0, 16'h0, 1'b0, 1'b0, 15'hFFF, 8'd2}, // R2
        '{16'h1123, 16'h1000, 1'b0, 1'b0, 4'd1, 16'h1000, 1'b0, 16'h0, 1'b1, 1'b0, 15'h0, 8'd3},   // R3
        '{16'h4000, 16'h1000, 1'b0, 1'b0, 4'd4, 16'h1000, 1'b0, 16'h0, 1'b1, 1'b0, 15'h0, 8'd9},   // R9
        '{16'h4ABC, 16'h1000, 1'b0, 1'b0, 4'd4, 16'h1001, 1'b0, 16'h0, 1'b0, 1'b0, 15'hABC, 8'd9}, // R9
        '{16'h7000, 16'h1000, 1'b0, 1'b0, 4'd7, 16'h1000, 1'b0, 16'h0, 1'b0, 1'b1, 15'h0, 8'd8},   // R8
        '{16'hFFFF, 16'h1000, 1'b0, 1'b0, 4'd8, 16'h1000, 1'b0, 16'h0, 1'b1, 1'b0, 15'h7FFF, 8'd10}, // R10
        '{16'h8443, 16'h1000, 1'b0, 1'b0, 4'd8, 16'h1001, 1'b0, 16'h0, 1'b0, 1'b0, 15'h0443, 8'd10}, // R10
        '{16'hF800, 16'h1000, 1'b0, 1'b0, 4'd8, 16'h1001, 1'b0, 16'h0, 1'b0, 1'b0, 15'h7800, 8'd10}, // R10
        '{16'h4001, 16'hFFFF, 1'b0, 1'b0, 4'd4, 16'h0000, 1'b0, 16'h0, 1'b0, 1'b0, 15'h001, 8'd1}   // R1
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input int i);
        string r;
        vec_t v;
        v = VEC[i];
        r = $sformatf("R%0d", v.req);
        @(negedge clk);
        in_valid = 1'b1; in_word = v.word; in_ip = v.ip; tos_zero = v.tz; tos_pos = v.tp;
        @(negedge clk);
        in_valid = 1'b0;
        chk(r, "out_valid R12", 32'(out_valid), 32'd1);
        chk(r, "kind R1", 32'(out_kind), 32'(v.kind));
        chk(r, "next_ip", 32'(next_ip), 32'(v.nxt));
        chk(r, "push_valid", 32'(push_valid), 32'(v.push));
        if (v.push) chk(r, "push_data", 32'(push_data), 32'(v.pdata));
        chk(r, "fault_illegal", 32'(fault_illegal), 32'(v.fi));
        chk(r, "fault_class", 32'(fault_class), 32'(v.fc));
        chk(r, "stall", 32'(stall), 32'd0);
        if (v.kind == 4'd0) chk(r, "pf_count", 32'(pf_count), 32'(v.aux));
        if (v.kind == 4'd4) chk(r, "prim_op", 32'(prim_op), 32'(v.aux));
        if (v.kind == 4'd8) chk(r, "pk fields", 32'({pk_a, pk_b, pk_c}), 32'(v.aux));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12: reset state
        chk("R12", "reset out_valid", 32'(out_valid), 32'd0);
        chk("R12", "reset push_valid", 32'(push_valid), 32'd0);
        chk("R12", "reset stall", 32'(stall), 32'd0);
        chk("R12", "reset faults", 32'({fault_illegal, fault_class}), 32'd0);
        chk("R12", "reset next_ip", 32'(next_ip), 32'd0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R8: method-table call with a word offered during the stall cycle
        @(negedge clk);
        in_valid = 1'b1; in_word = 16'h7005; in_ip = 16'h2000;
        #1;
        chk("R8", "mt_req", 32'(mt_req), 32'd1);
        chk("R8", "mt_idx", 32'(mt_idx), 32'h5);
        @(negedge clk);
        in_word = 16'h4ABC; in_ip = 16'h3000; mt_data = 16'h3456;
        chk("R8", "stall", 32'(stall), 32'd1);
        chk("R8", "out_valid in stall", 32'(out_valid), 32'd0);
        chk("R8", "mt_req in stall", 32'(mt_req), 32'd0);
        @(negedge clk);
        in_valid = 1'b0; mt_data = 16'h0;
        chk("R8", "out_valid", 32'(out_valid), 32'd1);
        chk("R8", "kind", 32'(out_kind), 32'd7);
        chk("R8", "next_ip", 32'(next_ip), 32'h3456);
        chk("R8", "push_valid", 32'(push_valid), 32'd1);
        chk("R8", "push_data", 32'(push_data), 32'h2001);
        chk("R8", "stall cleared", 32'(stall), 32'd0);
        @(negedge clk);
        chk("R8", "ignored word gave no result", 32'(out_valid), 32'd0);

        // R8: zero index issues no request
        in_valid = 1'b1; in_word = 16'h7000; in_ip = 16'h0100;
        #1;
        chk("R8", "no mt_req on zero index", 32'(mt_req), 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8", "zero index no stall", 32'(stall), 32'd0);

        // R12: idle gives no result
        @(negedge clk);
        chk("R12", "idle out_valid", 32'(out_valid), 32'd0);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule